// File: doc/BRIEF.md
# Current Monitor Measurement Sequencer

This block runs a single current measurement through an external sense amplifier and converter. When a request arrives while it is idle, it first pulls the monitor strobe low to discharge the previous reading. It then raises the strobe and holds it there for a settling interval. Next it issues a one-cycle start pulse to the converter. The strobe stays high until the converter has finished its sample phase.

When the converter signals completion, the sequencer captures the raw code. It then turns the code into a current in milliamps. The sense voltage reaches the converter after a fixed amplification of ten, so the current is code times reference voltage, divided by ten times 2^N times the sense resistance. The conversion uses a precomputed constant multiplier and a rounding right shift rather than a divider.

The discharge, settle and sample intervals are counted in clock cycles. Each has a parameter default and a run-time override. A sample setting that is shorter than the strobe's minimum high time is refused. A converter that never reports completion is abandoned after a bounded wait.

Top module: `cur_mon_seq`

## Requirements
- R1: While reset is high and after it is released, mon_strobe, adc_start, busy, res_valid, cfg_err and tmo_err are 0 and current_ma is 0. The timing registers hold their parameter defaults, which adc_smp_cyc shows.
- R2: A meas_req sampled at a clock edge while idle, with a valid sample setting, raises busy after that edge. The strobe is then held low for the programmed discharge count of cycles (at least one).
- R3: After discharge, the strobe is high for the programmed settle count of cycles before adc_start. adc_start is high for exactly one cycle, with the strobe high.
- R4: The strobe stays high while adc_sample is high. It falls in the cycle after the first cycle in which adc_sample is seen low, having been seen high since the start pulse.
- R5: adc_done, seen after the sample phase, captures adc_code. res_valid is high for exactly one cycle, three cycles after the cycle in which adc_done was high, and busy falls in that same cycle.
- R6: current_ma equals code x VREF_MV x 100 / (2^N x RSENSE_MOHM), rounded to nearest, and holds until the next result. With N=8, 2560 mV and 50 milliohm, code 75 gives 1500.
- R7: A meas_req that arrives while busy is high has no effect on the sequence or its outputs.
- R8: cfg_wr loads the discharge, settle and sample counts when busy is low, and is ignored while busy is high. adc_smp_cyc presents the sample count to the converter.
- R9: A meas_req while idle with a sample count below HI_MIN sets cfg_err and starts nothing: busy and the strobe stay low. Any meas_req taken while idle rewrites cfg_err from its own check and clears tmo_err.
- R10: If adc_done has not been captured within TMO_CYC cycles after the start pulse, the sequencer returns to idle. It drops busy and the strobe, sets tmo_err and gives no res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_req | input | 1 | Measurement request |
| cfg_wr | input | 1 | Load the three timing counts |
| cfg_dis_cyc | input | CW | Discharge count to load |
| cfg_set_cyc | input | CW | Settle count to load |
| cfg_smp_cyc | input | CW | Sample count to load |
| adc_sample | input | 1 | Converter is in its sample phase |
| adc_done | input | 1 | Converter result ready |
| adc_code | input | N_BITS | Converter result |
| mon_strobe | output | 1 | Current monitor strobe |
| adc_start | output | 1 | Converter start pulse |
| adc_smp_cyc | output | CW | Programmed sample count for the converter |
| busy | output | 1 | Measurement in progress |
| res_valid | output | 1 | One-cycle result strobe |
| current_ma | output | IW | Measured current in milliamps |
| cfg_err | output | 1 | Sample setting below minimum high time |
| tmo_err | output | 1 | Converter did not finish in time |

## Verification
The hardest cases to reach are the collisions between the sequence and outside inputs. One is a request or a configuration write that lands while a measurement is in flight. The other is a converter that stops after its sample phase and never reports. The bench uses a behavioural converter stub that can be told to withhold its done pulse, which forces the timeout path. It also fires extra requests and a configuration write in the middle of a running measurement. A reference model that is updated on every clock then shows whether either input left a trace on the outputs.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIS,
    ST_SET,
    ST_START,
    ST_SWAIT,
    ST_CWAIT,
    ST_SCALE,
    ST_DONE
  } cms_state_t;

endpackage

// File: rtl/cms_cfg_regs.sv
module cms_cfg_regs #(
  parameter int CW      = 8,
  parameter int DIS_DEF = 3,
  parameter int SET_DEF = 4,
  parameter int SMP_DEF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          busy,
  input  logic [CW-1:0] dis_in,
  input  logic [CW-1:0] set_in,
  input  logic [CW-1:0] smp_in,
  output logic [CW-1:0] dis_q,
  output logic [CW-1:0] set_q,
  output logic [CW-1:0] smp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= CW'(DIS_DEF);
      set_q <= CW'(SET_DEF);
      smp_q <= CW'(SMP_DEF);
    end else if (wr_en && !busy) begin
      dis_q <= dis_in;
      set_q <= set_in;
      smp_q <= smp_in;
    end
  end

endmodule

// File: rtl/cms_phase_ctl.sv
module cms_phase_ctl
  import cms_pkg::*;
#(
  parameter int CW      = 8,
  parameter int HI_MIN  = 4,
  parameter int TMO_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [CW-1:0] dis_cyc,
  input  logic [CW-1:0] set_cyc,
  input  logic [CW-1:0] smp_cyc,
  input  logic          adc_sample,
  input  logic          adc_done,
  output logic          strobe,
  output logic          adc_start,
  output logic          busy,
  output logic          cfg_err,
  output logic          tmo_err,
  output logic          cap_en,
  output logic          mul_en,
  output logic          out_en
);

  localparam int TW = $clog2(TMO_CYC + 1);

  cms_state_t    st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          seen;
  logic          smp_short;
  logic          dis_end;
  logic          set_end;
  logic          t_end;

  assign smp_short = (smp_cyc < CW'(HI_MIN));
  assign dis_end   = (({1'b0, cnt} + 1'b1) >= {1'b0, dis_cyc});
  assign set_end   = (({1'b0, cnt} + 1'b1) >= {1'b0, set_cyc});
  assign t_end     = (({1'b0, tcnt} + 1'b1) >= (TW + 1)'(TMO_CYC));

  assign cap_en = (st == ST_CWAIT) && adc_done;
  assign mul_en = (st == ST_SCALE);
  assign out_en = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      tcnt      <= '0;
      seen      <= 1'b0;
      strobe    <= 1'b0;
      adc_start <= 1'b0;
      busy      <= 1'b0;
      cfg_err   <= 1'b0;
      tmo_err   <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            cfg_err <= smp_short;
            tmo_err <= 1'b0;
            if (!smp_short) begin
              st   <= ST_DIS;
              busy <= 1'b1;
              cnt  <= '0;
            end
          end
        end
        ST_DIS: begin
          if (dis_end) begin
            st     <= ST_SET;
            strobe <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SET: begin
          if (set_end) begin
            st        <= ST_START;
            adc_start <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_START: begin
          st   <= ST_SWAIT;
          seen <= 1'b0;
          tcnt <= '0;
        end
        ST_SWAIT, ST_CWAIT: begin
          if (st == ST_CWAIT && adc_done) begin
            st <= ST_SCALE;
          end else if (t_end) begin
            st      <= ST_IDLE;
            strobe  <= 1'b0;
            busy    <= 1'b0;
            tmo_err <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
            if (st == ST_SWAIT) begin
              if (adc_sample) begin
                seen <= 1'b1;
              end else if (seen) begin
                st     <= ST_CWAIT;
                strobe <= 1'b0;
              end
            end
          end
        end
        ST_SCALE: st <= ST_DONE;
        ST_DONE: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cms_scaler.sv
module cms_scaler #(
  parameter int N_BITS      = 8,
  parameter int VREF_MV     = 2560,
  parameter int RSENSE_MOHM = 50,
  parameter int FRAC        = 16,
  parameter int IW          = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              mul_en,
  input  logic              out_en,
  input  logic [N_BITS-1:0] code,
  output logic [IW-1:0]     current_ma,
  output logic              valid
);

  localparam int    KW   = 40;
  localparam int    PW   = N_BITS + KW;
  localparam int    SH   = N_BITS + FRAC;
  localparam longint KNUM = longint'(VREF_MV) * 100 * (longint'(1) << FRAC);
  localparam longint KVAL = (KNUM + longint'(RSENSE_MOHM / 2)) / longint'(RSENSE_MOHM);
  localparam logic [KW-1:0] KMUL = KW'(KVAL);
  localparam logic [PW:0]   HALF = (PW + 1)'(1) << (SH - 1);

  logic [N_BITS-1:0] code_q;
  logic [PW-1:0]     prod;
  logic [PW:0]       sum;

  assign sum = {1'b0, prod} + HALF;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q     <= '0;
      prod       <= '0;
      current_ma <= '0;
      valid      <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (cap_en) code_q <= code;
      if (mul_en) prod <= {{KW{1'b0}}, code_q} * {{N_BITS{1'b0}}, KMUL};
      if (out_en) begin
        current_ma <= IW'(sum >> SH);
        valid      <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cur_mon_seq.sv
module cur_mon_seq #(
  parameter int N_BITS      = 8,
  parameter int VREF_MV     = 2560,
  parameter int RSENSE_MOHM = 50,
  parameter int FRAC        = 16,
  parameter int IW          = 16,
  parameter int CW          = 8,
  parameter int DIS_DEF     = 3,
  parameter int SET_DEF     = 4,
  parameter int SMP_DEF     = 5,
  parameter int HI_MIN      = 4,
  parameter int TMO_CYC     = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_req,
  input  logic              cfg_wr,
  input  logic [CW-1:0]     cfg_dis_cyc,
  input  logic [CW-1:0]     cfg_set_cyc,
  input  logic [CW-1:0]     cfg_smp_cyc,
  input  logic              adc_sample,
  input  logic              adc_done,
  input  logic [N_BITS-1:0] adc_code,
  output logic              mon_strobe,
  output logic              adc_start,
  output logic [CW-1:0]     adc_smp_cyc,
  output logic              busy,
  output logic              res_valid,
  output logic [IW-1:0]     current_ma,
  output logic              cfg_err,
  output logic              tmo_err
);

  logic [CW-1:0] dis_q;
  logic [CW-1:0] set_q;
  logic          cap_en;
  logic          mul_en;
  logic          out_en;

  cms_cfg_regs #(
    .CW(CW), .DIS_DEF(DIS_DEF), .SET_DEF(SET_DEF), .SMP_DEF(SMP_DEF)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .busy(busy),
    .dis_in(cfg_dis_cyc), .set_in(cfg_set_cyc), .smp_in(cfg_smp_cyc),
    .dis_q(dis_q), .set_q(set_q), .smp_q(adc_smp_cyc)
  );

  cms_phase_ctl #(
    .CW(CW), .HI_MIN(HI_MIN), .TMO_CYC(TMO_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .req(meas_req),
    .dis_cyc(dis_q), .set_cyc(set_q), .smp_cyc(adc_smp_cyc),
    .adc_sample(adc_sample), .adc_done(adc_done),
    .strobe(mon_strobe), .adc_start(adc_start), .busy(busy),
    .cfg_err(cfg_err), .tmo_err(tmo_err),
    .cap_en(cap_en), .mul_en(mul_en), .out_en(out_en)
  );

  cms_scaler #(
    .N_BITS(N_BITS), .VREF_MV(VREF_MV), .RSENSE_MOHM(RSENSE_MOHM),
    .FRAC(FRAC), .IW(IW)
  ) u_scl (
    .clk(clk), .rst(rst), .cap_en(cap_en), .mul_en(mul_en), .out_en(out_en),
    .code(adc_code), .current_ma(current_ma), .valid(res_valid)
  );

endmodule

// File: rtl/cur_mon_seq_chk.sv
module cur_mon_seq_chk (
  input logic clk,
  input logic rst,
  input logic mon_strobe,
  input logic adc_start,
  input logic adc_sample,
  input logic busy,
  input logic res_valid,
  input logic cfg_err,
  input logic tmo_err
);

  p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  p_start_under_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> mon_strobe);

  p_strobe_after_sample_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(mon_strobe) && !tmo_err) |-> !$past(adc_sample));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_valid_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);

  p_busy_starts_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !mon_strobe);

  p_cfg_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);

endmodule

bind cur_mon_seq cur_mon_seq_chk u_chk (
  .clk(clk), .rst(rst), .mon_strobe(mon_strobe), .adc_start(adc_start),
  .adc_sample(adc_sample), .busy(busy), .res_valid(res_valid),
  .cfg_err(cfg_err), .tmo_err(tmo_err)
);

// File: tb/cur_mon_seq_test.sv
module cur_mon_seq_test;

  localparam int CLK_PER = 10;
  localparam int NB      = 8;
  localparam int VREF    = 2560;
  localparam int RS      = 50;
  localparam int IW      = 16;
  localparam int CW      = 8;
  localparam int DIS_D   = 3;
  localparam int SET_D   = 4;
  localparam int SMP_D   = 5;
  localparam int HI_MIN  = 4;
  localparam int TMO     = 30;
  localparam int CONV    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic meas_req = 1'b0;
  logic cfg_wr = 1'b0;
  logic [CW-1:0] cfg_dis_cyc = '0;
  logic [CW-1:0] cfg_set_cyc = '0;
  logic [CW-1:0] cfg_smp_cyc = '0;
  logic adc_sample = 1'b0;
  logic adc_done = 1'b0;
  logic [NB-1:0] adc_code = '0;
  logic mon_strobe, adc_start, busy, res_valid, cfg_err, tmo_err;
  logic [CW-1:0] adc_smp_cyc;
  logic [IW-1:0] current_ma;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PER / 2) clk = ~clk;

  cur_mon_seq #(
    .N_BITS(NB), .VREF_MV(VREF), .RSENSE_MOHM(RS), .IW(IW), .CW(CW),
    .DIS_DEF(DIS_D), .SET_DEF(SET_D), .SMP_DEF(SMP_D),
    .HI_MIN(HI_MIN), .TMO_CYC(TMO)
  ) uut (
    .clk(clk), .rst(rst), .meas_req(meas_req), .cfg_wr(cfg_wr),
    .cfg_dis_cyc(cfg_dis_cyc), .cfg_set_cyc(cfg_set_cyc), .cfg_smp_cyc(cfg_smp_cyc),
    .adc_sample(adc_sample), .adc_done(adc_done), .adc_code(adc_code),
    .mon_strobe(mon_strobe), .adc_start(adc_start), .adc_smp_cyc(adc_smp_cyc),
    .busy(busy), .res_valid(res_valid), .current_ma(current_ma),
    .cfg_err(cfg_err), .tmo_err(tmo_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ma(input int code);
    longint num;
    longint den;
    num = longint'(code) * VREF * 100;
    den = (longint'(1) << NB) * RS;
    return int'((2 * num + den) / (2 * den));
  endfunction

  // behavioural converter stub
  int  s_left = 0;
  int  c_left = 0;
  bit  hang = 1'b0;
  logic [NB-1:0] next_code = '0;

  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (rst) begin
      adc_sample <= 1'b0;
      c_left     <= 0;
    end else if (adc_start) begin
      adc_sample <= 1'b1;
      s_left     <= int'(adc_smp_cyc);
    end else if (adc_sample) begin
      if (s_left <= 1) begin
        adc_sample <= 1'b0;
        c_left     <= CONV;
      end else begin
        s_left <= s_left - 1;
      end
    end else if (c_left > 0) begin
      if (c_left == 1 && !hang) begin
        adc_done <= 1'b1;
        adc_code <= next_code;
      end
      c_left <= c_left - 1;
    end
  end

  // reference model, advanced every clock
  int ph, left, waited, m_code;
  int m_dis, m_set, m_smp;
  bit seen, ob;
  bit e_strobe, e_start, e_busy, e_valid, e_cerr, e_terr;
  int e_cur;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; left = 0; waited = 0; seen = 0; m_code = 0;
      m_dis = DIS_D; m_set = SET_D; m_smp = SMP_D;
      e_strobe = 0; e_start = 0; e_busy = 0; e_valid = 0;
      e_cerr = 0; e_terr = 0; e_cur = 0;
    end else begin
      ob = e_busy;
      e_start = 0;
      e_valid = 0;
      case (ph)
        0: if (meas_req) begin
             e_terr = 0;
             if (m_smp < HI_MIN) e_cerr = 1;
             else begin e_cerr = 0; e_busy = 1; ph = 1; left = m_dis; end
           end
        1: begin left--; if (left <= 0) begin ph = 2; left = m_set; end end
        2: begin left--; if (left <= 0) begin ph = 3; e_start = 1; end end
        3: begin ph = 4; seen = 0; waited = 0; end
        4, 5: begin
             waited++;
             if (ph == 5 && adc_done) begin m_code = int'(adc_code); ph = 6; end
             else if (waited >= TMO) begin ph = 0; e_busy = 0; e_terr = 1; end
             else if (ph == 4) begin
               if (adc_sample) seen = 1;
               else if (seen) ph = 5;
             end
           end
        6: ph = 7;
        7: begin ph = 0; e_busy = 0; e_valid = 1; e_cur = exp_ma(m_code); end
        default: ph = 0;
      endcase
      e_strobe = (ph >= 2 && ph <= 4);
      if (cfg_wr && !ob) begin
        m_dis = int'(cfg_dis_cyc); m_set = int'(cfg_set_cyc); m_smp = int'(cfg_smp_cyc);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(mon_strobe == e_strobe, "R2/R3/R4 mon_strobe", int'(mon_strobe), int'(e_strobe));
      chk(adc_start == e_start, "R3 adc_start", int'(adc_start), int'(e_start));
      chk(busy == e_busy, "R7 busy", int'(busy), int'(e_busy));
      chk(res_valid == e_valid, "R5 res_valid", int'(res_valid), int'(e_valid));
      chk(int'(current_ma) == e_cur, "R6 current_ma", int'(current_ma), e_cur);
      chk(cfg_err == e_cerr, "R9 cfg_err", int'(cfg_err), int'(e_cerr));
      chk(tmo_err == e_terr, "R10 tmo_err", int'(tmo_err), int'(e_terr));
      chk(int'(adc_smp_cyc) == m_smp, "R8 adc_smp_cyc", int'(adc_smp_cyc), m_smp);
    end
  end

  task automatic pulse_req();
    @(negedge clk); meas_req = 1'b1;
    @(negedge clk); meas_req = 1'b0;
  endtask

  task automatic wait_free();
    do @(negedge clk); while (busy);
  endtask

  task automatic run_meas(input int code);
    next_code = NB'(code);
    pulse_req();
    wait_free();
  endtask

  task automatic write_cfg(input int d, input int s, input int m);
    @(negedge clk);
    cfg_dis_cyc = CW'(d); cfg_set_cyc = CW'(s); cfg_smp_cyc = CW'(m); cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk(!mon_strobe && !adc_start && !busy && !res_valid && !cfg_err && !tmo_err,
        "R1 control outputs low in reset", 1, 0);
    chk(current_ma == '0, "R1 current_ma in reset", int'(current_ma), 0);
    chk(int'(adc_smp_cyc) == SMP_D, "R1 sample default", int'(adc_smp_cyc), SMP_D);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R6: reference point 75 -> 1500 mA
    run_meas(75);
    chk(res_valid == 1'b1, "R5 valid with busy fall", int'(res_valid), 1);
    chk(int'(current_ma) == 1500, "R6 code 75 gives 1500 mA", int'(current_ma), 1500);

    // R6: several codes, including the extremes
    run_meas(0);
    run_meas(255);
    run_meas(1);
    run_meas(128);

    // R7 and R8: request and configuration write during a measurement
    next_code = 8'd33;
    pulse_req();
    repeat (3) @(negedge clk);
    meas_req = 1'b1;
    cfg_dis_cyc = 8'd9; cfg_set_cyc = 8'd9; cfg_smp_cyc = 8'd2; cfg_wr = 1'b1;
    @(negedge clk);
    meas_req = 1'b0; cfg_wr = 1'b0;
    repeat (6) @(negedge clk);
    meas_req = 1'b1;
    @(negedge clk);
    meas_req = 1'b0;
    wait_free();
    chk(int'(adc_smp_cyc) == SMP_D, "R8 write ignored while busy", int'(adc_smp_cyc), SMP_D);
    repeat (3) @(negedge clk);
    chk(!busy, "R7 extra request left no run", int'(busy), 0);

    // R2 boundary: one-cycle discharge, minimum legal sample count
    write_cfg(1, 2, HI_MIN);
    run_meas(99);
    chk(int'(current_ma) == exp_ma(99), "R6 code 99", int'(current_ma), exp_ma(99));

    // R9: sample count below minimum
    write_cfg(2, 3, HI_MIN - 2);
    pulse_req();
    repeat (3) @(negedge clk);
    chk(!busy && !mon_strobe, "R9 no start on bad sample count", int'(busy), 0);
    chk(cfg_err, "R9 cfg_err set", int'(cfg_err), 1);
    write_cfg(2, 3, 6);
    run_meas(200);
    chk(!cfg_err, "R9 cfg_err cleared by accepted request", int'(cfg_err), 0);

    // R10: converter never reports done
    hang = 1'b1;
    run_meas(50);
    chk(tmo_err, "R10 timeout flag", int'(tmo_err), 1);
    chk(int'(current_ma) == exp_ma(200), "R10 result kept after abort",
        int'(current_ma), exp_ma(200));
    hang = 1'b0;
    repeat (10) @(negedge clk);
    run_meas(10);
    chk(!tmo_err, "R10 flag cleared by next request", int'(tmo_err), 0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule